// File: doc/BRIEF.md
# Universal Serial Shift Interface

This block is a bare synchronous serial engine: an 8-bit shift register, a 4-bit edge counter and a holding register for the finished byte. Software picks how the shifter is paced. It can follow the edges of an external clock pin, with either edge used for sampling. It can follow compare-match pulses from a timer. It can follow single-cycle software strobes. Every higher framing rule is left to the software or the timer that drives it.

The same engine serves a three-wire link (data out, data in, clock) and a two-wire link (open-drain data and clock). In the two-wire case a start detector flags a falling data line while the clock is high. It can also stretch the clock low until software acknowledges the start. Counting both edges of each bit means the counter wraps after eight bits. The wrap raises an overflow flag and copies the received byte into the holding register, so software can read it while the next byte shifts in.

Top module: `ushift_top`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `data_q`, `buf_q`, `cnt_q`, `do_pin`, `clk_drive`, `ovf_flag` and `start_flag` are all zero.
- R2: A shift event moves `data_q` one place towards the MSB and enters the data-in pin level at bit 0. Both pins pass through `SYNC_STAGES` flip-flops and one edge-detect flop. Without a shift or a write, `data_q` holds. A write through `data_we` takes priority over a shift.
- R3: `cfg_src` selects the pacing source: 0 software strobes, 1 timer match, 2 external clock sampled on its rising edge, 3 external clock sampled on its falling edge. With source 2 or 3, both clock edges advance the counter and the sampling edge shifts.
- R4: `do_pin` is a latch of the data MSB. It is reloaded with the new MSB on every data write, and otherwise with the current MSB on the clock edge opposite to the sampling edge.
- R5: The counter advances by one per count event and wraps from 15 to 0. A software write through `cnt_we` overrides a count in the same cycle.
- R6: On the 15-to-0 wrap, `ovf_flag` sets and `buf_q` takes the value `data_q` has after that cycle's shift.
- R7: With source 0, `sw_shift` shifts once. `sw_toggle` inverts `clk_drive` and advances the counter. A toggle that takes `clk_drive` from 1 to 0 reloads `do_pin`.
- R8: With source 1, each `timer_match` inverts `clk_drive` and advances the counter. The shift happens on the 0-to-1 transition and the `do_pin` reload on the 1-to-0 transition.
- R9: `cfg_mode` encodes 0 off, 1 three-wire, 2 two-wire, 3 off. In two-wire mode the external sources always sample on the rising clock edge, and `sda_pull_low` is high exactly when the output latch is 0.
- R10: In two-wire mode, a synchronized data fall while the synchronized clock is high in both of the last two samples sets `start_flag`. `scl_hold_low` is high when two-wire mode, `cfg_hold_en` and `start_flag` are all set.
- R11: Writing 1 to `flag_clr` bit 0 clears `ovf_flag` and bit 1 clears `start_flag`. Writing 0 has no effect. A set in the same cycle wins over the clear.
- R12: In an off mode, no shift, count, latch reload or clock toggle happens. Software writes of data and counter still take effect.
- R13: `irq_ovf` equals `ovf_flag` AND `ovf_ie`. `irq_start` equals `start_flag` AND `start_ie`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Link mode: 0 off, 1 three-wire, 2 two-wire, 3 off |
| cfg_src | input | 2 | Pacing source: 0 software, 1 timer, 2 ext rising, 3 ext falling |
| cfg_hold_en | input | 1 | Stretch clock low while start flag is set (two-wire) |
| ovf_ie | input | 1 | Overflow interrupt enable |
| start_ie | input | 1 | Start interrupt enable |
| data_we | input | 1 | Load shift register |
| data_wdata | input | 8 | Value for shift register |
| cnt_we | input | 1 | Load edge counter |
| cnt_wdata | input | 4 | Value for edge counter |
| flag_clr | input | 2 | Write-one-to-clear: bit 0 overflow, bit 1 start |
| sw_shift | input | 1 | Software shift strobe |
| sw_toggle | input | 1 | Software clock toggle strobe |
| timer_match | input | 1 | Timer compare-match pulse |
| sck_pin | input | 1 | External serial clock level |
| di_pin | input | 1 | Serial data-in level |
| do_pin | output | 1 | Serial data out (output latch) |
| clk_drive | output | 1 | Clock level driven as master |
| sda_pull_low | output | 1 | Open-drain data pull-down (two-wire) |
| scl_hold_low | output | 1 | Open-drain clock hold (two-wire) |
| data_q | output | 8 | Shift register contents |
| buf_q | output | 8 | Last completed byte |
| cnt_q | output | 4 | Edge counter |
| ovf_flag | output | 1 | Counter wrap flag |
| start_flag | output | 1 | Start condition flag |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_start | output | 1 | Start interrupt request |

## Verification
Bytes move through the engine under all four pacing sources, each with its own data pattern (0x3C, 0xC3, 0x96, 0x5A, 0x81). A wrong bit order, a wrong sampling edge or a latch reloading on the wrong edge therefore shows up as a different received byte or output bit stream. A behavioural model follows every clock with its own pin history queues. Targeted sequences separate the priority cases: a counter write racing a count, a flag clear racing a wrap, a start condition with the clock high versus low, and clock activity in an off mode.

// File: rtl/ssi_pkg.sv
package ssi_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_3W   = 2'd1,
    MODE_2W   = 2'd2,
    MODE_OFF2 = 2'd3
  } ssi_mode_e;

  typedef enum logic [1:0] {
    SRC_SW       = 2'd0,
    SRC_TIMER    = 2'd1,
    SRC_EXT_RISE = 2'd2,
    SRC_EXT_FALL = 2'd3
  } ssi_src_e;

  typedef struct packed {
    logic shift;
    logic count;
    logic latch;
  } ssi_evt_t;
endpackage

// File: rtl/ssi_pin_sync.sv
module ssi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic lvl,
  output logic prev
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= pin;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= chain[STAGES-1];
  end

  assign lvl = chain[STAGES-1];

  // level seen now becomes the previous sample one cycle later
  assert_prev_follows_R2: assert property (@(posedge clk) disable iff (rst)
    lvl |=> prev);
endmodule

// File: rtl/ssi_event_sel.sv
module ssi_event_sel import ssi_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  logic       active,
  input  logic       two_wire,
  input  logic [1:0] src,
  input  logic       sw_shift,
  input  logic       sw_toggle,
  input  logic       timer_match,
  input  logic       sck_lvl,
  input  logic       sck_prev,
  output logic       clk_out,
  output ssi_evt_t   evt
);
  ssi_src_e src_eff;
  logic     rise_e;
  logic     fall_e;
  logic     toggle_e;

  assign rise_e = sck_lvl & ~sck_prev;
  assign fall_e = ~sck_lvl & sck_prev;

  always_comb begin
    src_eff = ssi_src_e'(src);
    if (two_wire && src_eff == SRC_EXT_FALL) src_eff = SRC_EXT_RISE;
  end

  always_comb begin
    evt      = '0;
    toggle_e = 1'b0;
    if (active) begin
      unique case (src_eff)
        SRC_SW: begin
          evt.shift = sw_shift;
          evt.count = sw_toggle;
          evt.latch = sw_toggle & clk_out;
          toggle_e  = sw_toggle;
        end
        SRC_TIMER: begin
          evt.shift = timer_match & ~clk_out;
          evt.count = timer_match;
          evt.latch = timer_match & clk_out;
          toggle_e  = timer_match;
        end
        SRC_EXT_RISE: begin
          evt.shift = rise_e;
          evt.count = rise_e | fall_e;
          evt.latch = fall_e;
          toggle_e  = sw_toggle;
        end
        SRC_EXT_FALL: begin
          evt.shift = fall_e;
          evt.count = rise_e | fall_e;
          evt.latch = rise_e;
          toggle_e  = sw_toggle;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           clk_out <= 1'b0;
    else if (toggle_e) clk_out <= ~clk_out;
  end

  assert_idle_clock_R12: assert property (@(posedge clk) disable iff (rst)
    !active |=> $stable(clk_out));
endmodule

// File: rtl/ssi_shift_unit.sv
module ssi_shift_unit import ssi_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  ssi_evt_t          evt,
  input  logic              di,
  input  logic              data_we,
  input  logic [DATA_W-1:0] data_wdata,
  input  logic              cnt_we,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              ovf_clr,
  output logic [DATA_W-1:0] data_q,
  output logic [DATA_W-1:0] buf_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              latch_q,
  output logic              ovf_q
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] data_nxt;
  logic              wrap;

  always_comb begin
    if (data_we)        data_nxt = data_wdata;
    else if (evt.shift) data_nxt = {data_q[MSB-1:0], di};
    else                data_nxt = data_q;
  end

  assign wrap = evt.count & ~cnt_we & (cnt_q == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      buf_q   <= '0;
      cnt_q   <= '0;
      latch_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      data_q <= data_nxt;
      if (cnt_we)         cnt_q <= cnt_wdata;
      else if (evt.count) cnt_q <= cnt_q + 1'b1;
      if (wrap) buf_q <= data_nxt;
      if (data_we)        latch_q <= data_wdata[MSB];
      else if (evt.latch) latch_q <= data_q[MSB];
      if (wrap)         ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
    end
  end

  assert_hold_data_R2: assert property (@(posedge clk) disable iff (rst)
    !(evt.shift || data_we) |=> $stable(data_q));

  assert_count_step_R5: assert property (@(posedge clk) disable iff (rst)
    (evt.count && !cnt_we) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  assert_buf_on_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (buf_q != $past(buf_q)) |-> (cnt_q == '0 && ovf_q));

  assert_wrap_sets_R11: assert property (@(posedge clk) disable iff (rst)
    (evt.count && !cnt_we && cnt_q == {CNT_W{1'b1}}) |=> ovf_q);
endmodule

// File: rtl/ushift_top.sv
module ushift_top import ssi_pkg::*; #(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_mode,
  input  logic [1:0]        cfg_src,
  input  logic              cfg_hold_en,
  input  logic              ovf_ie,
  input  logic              start_ie,
  input  logic              data_we,
  input  logic [DATA_W-1:0] data_wdata,
  input  logic              cnt_we,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic [1:0]        flag_clr,
  input  logic              sw_shift,
  input  logic              sw_toggle,
  input  logic              timer_match,
  input  logic              sck_pin,
  input  logic              di_pin,
  output logic              do_pin,
  output logic              clk_drive,
  output logic              sda_pull_low,
  output logic              scl_hold_low,
  output logic [DATA_W-1:0] data_q,
  output logic [DATA_W-1:0] buf_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              ovf_flag,
  output logic              start_flag,
  output logic              irq_ovf,
  output logic              irq_start
);
  ssi_mode_e mode;
  logic      active, two_wire;
  logic      sck_lvl, sck_prev, di_lvl, di_prev;
  logic      start_det, latch_q;
  ssi_evt_t  evt;

  assign mode     = ssi_mode_e'(cfg_mode);
  assign two_wire = (mode == MODE_2W);
  assign active   = (mode == MODE_3W) || two_wire;

  ssi_pin_sync #(.STAGES(SYNC_STAGES)) u_sck_sync (
    .clk(clk), .rst(rst), .pin(sck_pin), .lvl(sck_lvl), .prev(sck_prev)
  );

  ssi_pin_sync #(.STAGES(SYNC_STAGES)) u_di_sync (
    .clk(clk), .rst(rst), .pin(di_pin), .lvl(di_lvl), .prev(di_prev)
  );

  ssi_event_sel u_evt (
    .clk(clk), .rst(rst), .active(active), .two_wire(two_wire), .src(cfg_src),
    .sw_shift(sw_shift), .sw_toggle(sw_toggle), .timer_match(timer_match),
    .sck_lvl(sck_lvl), .sck_prev(sck_prev), .clk_out(clk_drive), .evt(evt)
  );

  ssi_shift_unit #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst(rst), .evt(evt), .di(di_lvl),
    .data_we(data_we), .data_wdata(data_wdata),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .ovf_clr(flag_clr[0]),
    .data_q(data_q), .buf_q(buf_q), .cnt_q(cnt_q),
    .latch_q(latch_q), .ovf_q(ovf_flag)
  );

  assign start_det = two_wire & di_prev & ~di_lvl & sck_lvl & sck_prev;

  always_ff @(posedge clk) begin
    if (rst)              start_flag <= 1'b0;
    else if (start_det)   start_flag <= 1'b1;
    else if (flag_clr[1]) start_flag <= 1'b0;
  end

  assign do_pin       = latch_q;
  assign sda_pull_low = two_wire & ~latch_q;
  assign scl_hold_low = two_wire & cfg_hold_en & start_flag;
  assign irq_ovf      = ovf_flag & ovf_ie;
  assign irq_start    = start_flag & start_ie;

  assert_start_only_2w_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(start_flag) |-> $past(two_wire));

  assert_hold_needs_start_R10: assert property (@(posedge clk) disable iff (rst)
    scl_hold_low |-> start_flag);

  assert_irq_gated_R13: assert property (@(posedge clk) disable iff (rst)
    (irq_ovf |-> ovf_flag) and (irq_start |-> start_flag));
endmodule

// File: tb/ushift_top_tb_top.sv
module ushift_top_tb_top;
  localparam int S = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cfg_mode = '0, cfg_src = '0, flag_clr = '0;
  logic       cfg_hold_en = 0, ovf_ie = 0, start_ie = 0;
  logic       data_we = 0, cnt_we = 0, sw_shift = 0, sw_toggle = 0, timer_match = 0;
  logic [7:0] data_wdata = '0;
  logic [3:0] cnt_wdata = '0;
  logic       sck_pin = 0, di_pin = 0;
  logic       do_pin, clk_drive, sda_pull_low, scl_hold_low;
  logic [7:0] data_q, buf_q;
  logic [3:0] cnt_q;
  logic       ovf_flag, start_flag, irq_ovf, irq_start;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ushift_top #(.DATA_W(8), .CNT_W(4), .SYNC_STAGES(S)) dut_i (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_src(cfg_src),
    .cfg_hold_en(cfg_hold_en), .ovf_ie(ovf_ie), .start_ie(start_ie),
    .data_we(data_we), .data_wdata(data_wdata), .cnt_we(cnt_we),
    .cnt_wdata(cnt_wdata), .flag_clr(flag_clr), .sw_shift(sw_shift),
    .sw_toggle(sw_toggle), .timer_match(timer_match), .sck_pin(sck_pin),
    .di_pin(di_pin), .do_pin(do_pin), .clk_drive(clk_drive),
    .sda_pull_low(sda_pull_low), .scl_hold_low(scl_hold_low),
    .data_q(data_q), .buf_q(buf_q), .cnt_q(cnt_q), .ovf_flag(ovf_flag),
    .start_flag(start_flag), .irq_ovf(irq_ovf), .irq_start(irq_start)
  );

  // ---------------- behavioural reference model ----------------
  int m_data, m_buf, m_cnt, m_latch, m_ovf, m_start, m_clk;
  int sck_hist[$];
  int di_hist[$];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int sl, sp, dl, dp, src, sh, cn, la, tg, nd, wrap;
    bit act, tw;
    if (rst) begin
      m_data = 0; m_buf = 0; m_cnt = 0; m_latch = 0; m_ovf = 0; m_start = 0; m_clk = 0;
      sck_hist.delete(); di_hist.delete();
      for (int i = 0; i <= S; i++) begin sck_hist.push_back(0); di_hist.push_back(0); end
      return;
    end
    // oldest entry is S+1 samples back, next is S samples back
    sp = sck_hist[0]; sl = sck_hist[1];
    dp = di_hist[0];  dl = di_hist[1];
    tw  = (cfg_mode == 2);
    act = (cfg_mode == 1) || tw;
    src = cfg_src;
    if (tw && src == 3) src = 2;
    sh = 0; cn = 0; la = 0; tg = 0;
    if (act) begin
      case (src)
        0: begin sh = sw_shift; cn = sw_toggle; la = sw_toggle && m_clk; tg = sw_toggle; end
        1: begin sh = timer_match && !m_clk; cn = timer_match; la = timer_match && m_clk; tg = timer_match; end
        2: begin sh = sl && !sp; cn = (sl != sp); la = !sl && sp; tg = sw_toggle; end
        default: begin sh = !sl && sp; cn = (sl != sp); la = sl && !sp; tg = sw_toggle; end
      endcase
    end
    if (data_we) nd = data_wdata;
    else if (sh) nd = ((m_data << 1) | dl) & 8'hFF;
    else nd = m_data;
    wrap = cn && !cnt_we && (m_cnt == 15);
    if (data_we) m_latch = data_wdata[7];
    else if (la) m_latch = (m_data >> 7) & 1;
    if (cnt_we) m_cnt = cnt_wdata;
    else if (cn) m_cnt = (m_cnt + 1) % 16;
    if (wrap) m_buf = nd;
    if (wrap) m_ovf = 1; else if (flag_clr[0]) m_ovf = 0;
    if (tw && dp && !dl && sl && sp) m_start = 1;
    else if (flag_clr[1]) m_start = 0;
    if (tg) m_clk = m_clk ^ 1;
    m_data = nd;
    sck_hist.push_back(int'(sck_pin)); void'(sck_hist.pop_front());
    di_hist.push_back(int'(di_pin));   void'(di_hist.pop_front());
  endtask

  always @(posedge clk) begin
    model_step();
    #1;
    chk("R2 data_q", int'(data_q), m_data);
    chk("R6 buf_q", int'(buf_q), m_buf);
    chk("R5 cnt_q", int'(cnt_q), m_cnt);
    chk("R4 do_pin", int'(do_pin), m_latch);
    chk("R7 clk_drive", int'(clk_drive), m_clk);
    chk("R11 ovf_flag", int'(ovf_flag), m_ovf);
    chk("R10 start_flag", int'(start_flag), m_start);
    chk("R9 sda_pull_low", int'(sda_pull_low), int'(cfg_mode == 2 && m_latch == 0));
    chk("R10 scl_hold_low", int'(scl_hold_low), int'(cfg_mode == 2 && cfg_hold_en && m_start));
    chk("R13 irq_ovf", int'(irq_ovf), int'(ovf_ie && m_ovf));
    chk("R13 irq_start", int'(irq_start), int'(start_ie && m_start));
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_data(input logic [7:0] v);
    @(negedge clk); data_we = 1; data_wdata = v;
    @(negedge clk); data_we = 0;
  endtask

  task automatic wr_cnt(input logic [3:0] v);
    @(negedge clk); cnt_we = 1; cnt_wdata = v;
    @(negedge clk); cnt_we = 0;
  endtask

  task automatic clr(input logic [1:0] m);
    @(negedge clk); flag_clr = m;
    @(negedge clk); flag_clr = 0;
  endtask

  task automatic pulse_shift();
    @(negedge clk); sw_shift = 1;
    @(negedge clk); sw_shift = 0;
  endtask

  task automatic pulse_toggle();
    @(negedge clk); sw_toggle = 1;
    @(negedge clk); sw_toggle = 0;
  endtask

  task automatic pulse_timer();
    @(negedge clk); timer_match = 1;
    @(negedge clk); timer_match = 0;
  endtask

  task automatic ext_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); di_pin = b[i];
      tick(2); sck_pin = 1;
      tick(4); sck_pin = 0;
      tick(2);
    end
    tick(S + 3);
  endtask

  initial begin
    #(5.0 * 100000);
    $display("FAIL watchdog expired");
    errors++;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst = 0;
    tick(1);
    // R1: reset state
    chk("R1 data", int'(data_q), 0);
    chk("R1 cnt", int'(cnt_q), 0);
    chk("R1 flags", int'({ovf_flag, start_flag, do_pin, clk_drive}), 0);

    // R3/R4: three-wire, rising-edge sampling
    cfg_mode = 1; cfg_src = 2;
    wr_data(8'hA5);
    chk("R4 latch on write", int'(do_pin), 1);
    ext_byte(8'h3C);
    chk("R6 buf rising", int'(buf_q), 8'h3C);
    chk("R6 ovf set", int'(ovf_flag), 1);
    chk("R5 cnt wrapped", int'(cnt_q), 0);
    clr(2'b00);
    chk("R11 zero write keeps", int'(ovf_flag), 1);
    ovf_ie = 1; tick(1);
    chk("R13 irq_ovf", int'(irq_ovf), 1);
    clr(2'b01);
    chk("R11 clear ovf", int'(ovf_flag), 0);

    // R3: falling-edge sampling
    cfg_src = 3;
    wr_data(8'h0F);
    ext_byte(8'hC3);
    chk("R3 buf falling", int'(buf_q), 8'hC3);
    clr(2'b01);

    // R7: software strobes
    cfg_src = 0;
    for (int i = 7; i >= 0; i--) begin
      logic [7:0] pat = 8'h96;
      @(negedge clk); di_pin = pat[i];
      tick(S + 1);
      pulse_toggle(); pulse_shift(); pulse_toggle();
    end
    tick(1);
    chk("R7 buf software", int'(buf_q), 8'h96);
    chk("R7 clk idle low", int'(clk_drive), 0);
    clr(2'b01);

    // R8: timer pacing
    cfg_src = 1;
    for (int i = 7; i >= 0; i--) begin
      logic [7:0] pat = 8'h5A;
      @(negedge clk); di_pin = pat[i];
      tick(S + 1);
      pulse_timer(); pulse_timer();
    end
    tick(1);
    chk("R8 buf timer", int'(buf_q), 8'h5A);
    clr(2'b01);

    // R5: write overrides a same-cycle count
    cfg_src = 0;
    @(negedge clk); cnt_we = 1; cnt_wdata = 4'd3; sw_toggle = 1;
    @(negedge clk); cnt_we = 0; sw_toggle = 0;
    chk("R5 write wins", int'(cnt_q), 3);
    // R11: set wins over clear at wrap
    wr_cnt(4'd15);
    @(negedge clk); sw_toggle = 1; flag_clr = 2'b01;
    @(negedge clk); sw_toggle = 0; flag_clr = 0;
    chk("R11 set wins", int'(ovf_flag), 1);
    chk("R5 wrap to zero", int'(cnt_q), 0);
    clr(2'b01);

    // R10/R13: start condition in two-wire mode
    cfg_mode = 2; cfg_src = 3; cfg_hold_en = 1; start_ie = 1;
    @(negedge clk); di_pin = 1; tick(S + 2);
    sck_pin = 1; tick(S + 2);
    di_pin = 0; tick(S + 3);
    chk("R10 start set", int'(start_flag), 1);
    chk("R10 clock held", int'(scl_hold_low), 1);
    chk("R13 irq_start", int'(irq_start), 1);
    clr(2'b10);
    chk("R11 clear start", int'(start_flag), 0);
    sck_pin = 0; tick(S + 2);
    di_pin = 1; tick(S + 2);
    di_pin = 0; tick(S + 3);
    chk("R10 no start clock low", int'(start_flag), 0);

    // R9: two-wire byte, falling selection forced to rising
    wr_data(8'h7F);
    chk("R9 sda pull", int'(sda_pull_low), 1);
    wr_cnt(4'd0);
    ext_byte(8'h81);
    chk("R9 buf two-wire", int'(buf_q), 8'h81);
    clr(2'b01);

    // R12: off mode ignores clocks, writes still work
    cfg_mode = 0; cfg_src = 2;
    wr_cnt(4'd5);
    repeat (3) begin
      @(negedge clk); sck_pin = 1; tick(S + 2); sck_pin = 0; tick(S + 2);
    end
    pulse_toggle();
    tick(S + 2);
    chk("R12 cnt frozen", int'(cnt_q), 5);
    chk("R12 clock frozen", int'(clk_drive), 0);
    wr_data(8'h11);
    chk("R12 write works", int'(data_q), 8'h11);

    tick(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule